// File: doc/BRIEF.md
# Length-Framed Serial Packet Receiver

This block sits behind a serial receiver that hands over one byte at a time, each with framing, overrun and parity error flags. It gathers length-prefixed packets into a local byte buffer through a write port. Every packet starts with a destination byte. A length byte follows, then the payload and a closing check byte. The packet length is learnt from the second byte and checked against the buffer capacity. A finished packet is held until the consumer releases it.

A three-state mode machine decides the fate of each byte: it is stored, discarded, or counted as missed. Four 16-bit statistics counters record I/O errors, missed bytes, content errors and received packets. An idle timer with a programmable limit drops an abandoned partial packet or an error episode, and the receiver then waits for a fresh packet.

Top module: `lenframe_rx`

## Requirements
- R1: After reset, `rx_state` is reading (encoding 0 = reading, 1 = skipping, 2 = message received), `msg_ready` is low, `byte_count` is 0 and all four counters are 0.
- R2: A byte with any of the framing, overrun or parity flags set is never written, increments `cnt_io_err` and moves the receiver to skipping, whatever the current state.
- R3: A byte that arrives in message-received state, with no release in the same cycle, is not written. It increments `cnt_missed`, moves the receiver to skipping and drops `msg_ready`.
- R4: A byte that arrives in reading state while `buf_ready` is low is not written. It increments `cnt_missed` and moves the receiver to skipping.
- R5: In skipping state, error-free bytes are never written, and each byte restarts the idle timer.
- R6: In reading state, each accepted byte is written one cycle later on the write port. The first byte of a packet goes to address 0 and each later byte to the next address. `byte_count` increments with each one.
- R7: The second stored byte L gives the total packet length L+3. If L+3 >= BUF_SIZE-1, the packet is rejected: `cnt_content` increments and the receiver enters skipping. The length byte itself is still written.
- R8: When the last byte of an accepted packet has been stored, `cnt_packets` increments, `rx_state` becomes message received and `msg_ready` rises. The state holds, with the idle timer inactive, until a release or a further byte arrives.
- R9: A one-cycle `release_pulse` in message-received state returns the receiver to reading with `byte_count` 0. A byte that arrives in the same cycle is stored as the first byte of a new packet at address 0. A release in any other state has no effect.
- R10: The receiver returns to reading with `byte_count` 0 after `idle_limit`+1 consecutive cycles with no byte. This applies in skipping state, and in reading state when at least one byte is stored. After only `idle_limit` idle cycles the state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_data | input | 8 | Received byte |
| in_frame_err | input | 1 | Framing error on this byte |
| in_overrun_err | input | 1 | Overrun error on this byte |
| in_parity_err | input | 1 | Parity error on this byte |
| buf_ready | input | 1 | A receive buffer is assigned |
| release_pulse | input | 1 | Consumer has taken the finished packet |
| idle_limit | input | TW | Idle timeout in cycles |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | $clog2(BUF_SIZE) | Buffer write address |
| wr_data | output | 8 | Buffer write data |
| msg_ready | output | 1 | A complete packet is held in the buffer |
| rx_state | output | 2 | Current mode (0 reading, 1 skipping, 2 message received) |
| byte_count | output | $clog2(BUF_SIZE+1) | Bytes stored for the current packet |
| cnt_io_err | output | 16 | Bytes received with a line error |
| cnt_missed | output | 16 | Bytes that could not be taken |
| cnt_content | output | 16 | Packets rejected for length |
| cnt_packets | output | 16 | Packets completed |

## Verification
The bench targets the length limit from both sides. A payload length of 11 must complete in a 16-byte buffer and a length of 12 must be rejected; a comparison off by one would pass the second or reject the first. It also targets the exact idle cycle on which the timeout fires, so a timer that counts one cycle early or late shows up, as does skip mode that forgets to restart the timer on a byte. Two cases involve a release. When a release and a byte arrive together, a design that ignores the release would count the byte as missed. A release outside message-received state must not rewind the write address.

// File: rtl/lfr_pkg.sv
// Shared types for the length-framed receiver.
package lfr_pkg;
    typedef enum logic [1:0] {
        ST_READ = 2'd0,
        ST_SKIP = 2'd1,
        ST_DONE = 2'd2
    } rx_state_e;

    localparam int CNT_IO      = 0;
    localparam int CNT_MISSED  = 1;
    localparam int CNT_CONTENT = 2;
    localparam int CNT_PACKETS = 3;
    localparam int NUM_CNT     = 4;
endpackage

// File: rtl/lfr_stat_bank.sv
// Bank of wrapping statistics counters. Each counter increments by one in
// any cycle where its bump bit is high. Assumes bump is a registered-domain
// single-cycle strobe.
module lfr_stat_bank #(
    parameter int N = 4,
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      bump,
    output logic [N-1:0][W-1:0] value
);
    for (genvar i = 0; i < N; i++) begin : g_cnt
        // One counter per statistic.
        always_ff @(posedge clk) begin
            if (!rst_n)
                value[i] <= '0;
            else if (bump[i])
                value[i] <= value[i] + W'(1);
        end
    end
endmodule

// File: rtl/lfr_idle_timer.sv
// Idle timer: counts cycles while armed and not restarted, and reports
// expiry once the count reaches the limit. Assumes the owner leaves the
// armed condition once it has acted on expiry.
module lfr_idle_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          armed,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] count;

    assign expired = armed && (count >= limit);

    // Count idle cycles, clearing on activity or when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (restart || !armed)
            count <= '0;
        else if (!expired)
            count <= count + TW'(1);
    end

    assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0));
endmodule

// File: rtl/lenframe_rx.sv
// Length-framed packet receiver. Takes bytes with line-error flags, writes
// accepted bytes into a buffer and learns the packet length from the second
// byte. It holds a finished packet until release and keeps statistics.
// Assumes in_valid is at most one byte per cycle and release_pulse is one cycle.
module lenframe_rx
    import lfr_pkg::*;
#(
    parameter int BUF_SIZE = 16,
    parameter int TW       = 8,
    localparam int AW      = $clog2(BUF_SIZE),
    localparam int LW      = $clog2(BUF_SIZE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_frame_err,
    input  logic          in_overrun_err,
    input  logic          in_parity_err,
    input  logic          buf_ready,
    input  logic          release_pulse,
    input  logic [TW-1:0] idle_limit,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          msg_ready,
    output logic [1:0]    rx_state,
    output logic [LW-1:0] byte_count,
    output logic [15:0]   cnt_io_err,
    output logic [15:0]   cnt_missed,
    output logic [15:0]   cnt_content,
    output logic [15:0]   cnt_packets
);
    localparam logic [9:0]    LEN_LIMIT = 10'(BUF_SIZE - 1);
    localparam logic [LW-1:0] FULL_LEFT = LW'(BUF_SIZE);

    rx_state_e     mode, n_mode, eff_mode;
    logic [AW-1:0] pos, n_pos, eff_pos;
    logic [LW-1:0] used, n_used, eff_used;
    logic [LW-1:0] left, n_left, eff_left;
    logic [NUM_CNT-1:0] bump;
    logic [NUM_CNT-1:0][15:0] cnt_val;
    logic          store, any_err, take_release, armed, expired;
    logic [9:0]    total;

    assign any_err      = in_frame_err || in_overrun_err || in_parity_err;
    assign take_release = release_pulse && (mode == ST_DONE);
    assign armed        = (mode == ST_SKIP) || ((mode == ST_READ) && (used != '0));
    assign total        = {2'b00, in_data} + 10'd3;

    // Apply a release first so a same-cycle byte sees a fresh buffer.
    always_comb begin
        eff_mode = take_release ? ST_READ   : mode;
        eff_pos  = take_release ? '0        : pos;
        eff_used = take_release ? '0        : used;
        eff_left = take_release ? FULL_LEFT : left;
    end

    // Mode machine: decide the fate of each byte and the next buffer state.
    always_comb begin
        n_mode = eff_mode;
        n_pos  = eff_pos;
        n_used = eff_used;
        n_left = eff_left;
        bump   = '0;
        store  = 1'b0;
        if (in_valid) begin
            if (any_err) begin
                bump[CNT_IO] = 1'b1;
                n_mode       = ST_SKIP;
            end else begin
                unique case (eff_mode)
                    ST_READ: begin
                        if (!buf_ready) begin
                            bump[CNT_MISSED] = 1'b1;
                            n_mode           = ST_SKIP;
                        end else begin
                            store  = 1'b1;
                            n_pos  = eff_pos + AW'(1);
                            n_used = eff_used + LW'(1);
                            n_left = eff_left - LW'(1);
                            if (n_left == '0) begin
                                bump[CNT_PACKETS] = 1'b1;
                                n_mode            = ST_DONE;
                            end else if (n_used == LW'(2)) begin
                                if (total >= LEN_LIMIT) begin
                                    bump[CNT_CONTENT] = 1'b1;
                                    n_mode            = ST_SKIP;
                                end else begin
                                    n_left = LW'(total - 10'd2);
                                end
                            end
                        end
                    end
                    ST_SKIP: ;
                    default: begin
                        bump[CNT_MISSED] = 1'b1;
                        n_mode           = ST_SKIP;
                    end
                endcase
            end
        end else if (expired) begin
            n_mode = ST_READ;
            n_pos  = '0;
            n_used = '0;
            n_left = FULL_LEFT;
        end
    end

    // State and buffer bookkeeping registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= ST_READ;
            pos  <= '0;
            used <= '0;
            left <= FULL_LEFT;
        end else begin
            mode <= n_mode;
            pos  <= n_pos;
            used <= n_used;
            left <= n_left;
        end
    end

    // Registered buffer write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= store;
            wr_addr <= eff_pos;
            wr_data <= in_data;
        end
    end

    lfr_stat_bank #(.N(NUM_CNT), .W(16)) u_stats (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (bump),
        .value (cnt_val)
    );

    lfr_idle_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (in_valid),
        .armed   (armed),
        .limit   (idle_limit),
        .expired (expired)
    );

    assign cnt_io_err  = cnt_val[CNT_IO];
    assign cnt_missed  = cnt_val[CNT_MISSED];
    assign cnt_content = cnt_val[CNT_CONTENT];
    assign cnt_packets = cnt_val[CNT_PACKETS];
    assign msg_ready   = (mode == ST_DONE);
    assign rx_state    = mode;
    assign byte_count  = used;

    assert_err_skips_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_err) |=> (rx_state == 2'd1 && !wr_en));
    assert_err_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_err) |=> (cnt_io_err == $past(cnt_io_err) + 16'd1));
    assert_nobuf_missed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !any_err && !buf_ready && mode == ST_READ && !take_release)
        |=> (cnt_missed == $past(cnt_missed) + 16'd1));
    assert_skip_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == ST_SKIP) |=> !wr_en);
    assert_done_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_ready) |-> (cnt_packets == $past(cnt_packets) + 16'd1));
    assert_release_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_release && !in_valid) |=> (byte_count == '0 && rx_state == 2'd0));
endmodule

// File: tb/lenframe_rx_bench.sv
module lenframe_rx_bench;
    localparam int BUF_SIZE = 16;
    localparam int TW       = 8;
    localparam int AW       = $clog2(BUF_SIZE);
    localparam int LW       = $clog2(BUF_SIZE + 1);
    localparam int T        = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic in_frame_err = 1'b0, in_overrun_err = 1'b0, in_parity_err = 1'b0;
    logic buf_ready = 1'b1;
    logic release_pulse = 1'b0;
    logic [TW-1:0] idle_limit = TW'(T);
    logic wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0] wr_data;
    logic msg_ready;
    logic [1:0] rx_state;
    logic [LW-1:0] byte_count;
    logic [15:0] cnt_io_err, cnt_missed, cnt_content, cnt_packets;

    int checks = 0;
    int errors = 0;
    logic [11:0] exp_q[$];

    always #5 clk = ~clk;

    lenframe_rx #(.BUF_SIZE(BUF_SIZE), .TW(TW)) u_lenframe_rx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_frame_err(in_frame_err), .in_overrun_err(in_overrun_err),
        .in_parity_err(in_parity_err), .buf_ready(buf_ready),
        .release_pulse(release_pulse), .idle_limit(idle_limit),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .msg_ready(msg_ready), .rx_state(rx_state), .byte_count(byte_count),
        .cnt_io_err(cnt_io_err), .cnt_missed(cnt_missed),
        .cnt_content(cnt_content), .cnt_packets(cnt_packets)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: compare every buffer write with the scoreboard queue (R6).
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R6 unexpected write: actual addr %0d data %0d expected none",
                         wr_addr, wr_data);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                if ({4'(wr_addr), wr_data} != e) begin
                    errors++;
                    $display("FAIL R6 write: actual %0h expected %0h",
                             {4'(wr_addr), wr_data}, e);
                end
            end
        end
    end

    // Driver: one byte for one cycle; pushes the expected write if stored.
    task automatic send(input logic [7:0] d, input logic [2:0] err,
                        input bit stored, input int addr, input bit rel = 1'b0);
        in_valid = 1'b1;
        in_data = d;
        {in_frame_err, in_overrun_err, in_parity_err} = err;
        release_pulse = rel;
        if (stored) exp_q.push_back({4'(addr), d});
        @(negedge clk);
        in_valid = 1'b0;
        {in_frame_err, in_overrun_err, in_parity_err} = 3'b000;
        release_pulse = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_release();
        release_pulse = 1'b1;
        @(negedge clk);
        release_pulse = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 state", rx_state, 0);
        check("R1 msg_ready", msg_ready, 0);
        check("R1 byte_count", byte_count, 0);
        check("R1 counters", cnt_io_err + cnt_missed + cnt_content + cnt_packets, 0);

        // R6 R8: short packet, payload 2, total 5
        send(8'h5A, 3'b000, 1, 0);
        send(8'h02, 3'b000, 1, 1);
        send(8'h11, 3'b000, 1, 2);
        send(8'h22, 3'b000, 1, 3);
        check("R8 not yet done", msg_ready, 0);
        send(8'h99, 3'b000, 1, 4);
        check("R8 done state", rx_state, 2);
        check("R8 packets", cnt_packets, 1);
        check("R6 byte_count", byte_count, 5);
        idle(T + 5);
        check("R8 held without timeout", msg_ready, 1);

        // R3: byte in message-received state
        send(8'h33, 3'b000, 0, 0);
        check("R3 missed", cnt_missed, 1);
        check("R3 skip", rx_state, 1);
        check("R3 msg_ready", msg_ready, 0);

        // R5: skip bytes restart timer; R10 exact timeout cycle
        for (int i = 0; i < 4; i++) begin
            idle(T - 2);
            send(8'hC0 + 8'(i), 3'b000, 0, 0);
        end
        check("R5 still skipping", rx_state, 1);
        idle(T);
        check("R10 not yet", rx_state, 1);
        idle(1);
        check("R10 timeout to reading", rx_state, 0);
        check("R10 empty", byte_count, 0);

        // R7 boundary accepted: length 11 -> total 14
        send(8'h01, 3'b000, 1, 0);
        send(8'd11, 3'b000, 1, 1);
        for (int i = 2; i < 14; i++) send(8'(i * 7), 3'b000, 1, i);
        check("R7 len 11 accepted", rx_state, 2);
        check("R7 packets", cnt_packets, 2);
        check("R7 no content err", cnt_content, 0);
        pulse_release();
        check("R9 release state", rx_state, 0);
        check("R9 release count", byte_count, 0);

        // R7 boundary rejected: length 12 -> total 15
        send(8'h02, 3'b000, 1, 0);
        send(8'd12, 3'b000, 1, 1);
        check("R7 len 12 rejected", cnt_content, 1);
        check("R7 skip", rx_state, 1);
        send(8'h44, 3'b000, 0, 0);
        idle(T + 1);
        check("R10 back", rx_state, 0);

        // R2: error flags, in reading mid-packet then in skipping
        send(8'h03, 3'b000, 1, 0);
        send(8'h04, 3'b001, 0, 0);
        check("R2 parity io", cnt_io_err, 1);
        check("R2 skip", rx_state, 1);
        send(8'h05, 3'b010, 0, 0);
        send(8'h06, 3'b100, 0, 0);
        check("R2 overrun+frame io", cnt_io_err, 3);
        idle(T + 1);

        // R4: no buffer assigned
        buf_ready = 1'b0;
        send(8'h07, 3'b000, 0, 0);
        check("R4 missed", cnt_missed, 2);
        check("R4 skip", rx_state, 1);
        buf_ready = 1'b1;
        idle(T + 1);
        check("R4 recovered", rx_state, 0);

        // R9: release outside message-received is ignored
        send(8'h08, 3'b000, 1, 0);
        pulse_release();
        check("R9 ignored count", byte_count, 1);
        send(8'h00, 3'b000, 1, 1);
        send(8'hEE, 3'b000, 1, 2);
        check("R9 packet done", cnt_packets, 3);

        // R9: release coinciding with a byte
        send(8'h77, 3'b000, 1, 0, 1'b1);
        check("R9 coincident state", rx_state, 0);
        check("R9 coincident count", byte_count, 1);
        check("R9 coincident missed", cnt_missed, 2);

        // R10: partial packet in reading times out
        idle(T);
        check("R10 partial held", byte_count, 1);
        idle(1);
        check("R10 partial dropped", byte_count, 0);

        idle(2);
        check("R6 all writes seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule